// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It runs on the oscillator-rate clock and divides it by a programmable integer N = 16·M + A. A 15-bit ratio word is split into a 4-bit swallow count A (low bits) and an 11-bit cycle count M (high bits). Inside every output period the dual-modulus prescaler stage divides by 17 for the first A of its cycles and by 16 for the remaining M − A cycles, so the period is 17·A + 16·(M − A) = 16·M + A input clocks.

Once per period the block emits a one-clock pulse to the phase comparator. It also emits a half-rate square wave for a test pin. The ratio word is sampled only at a period boundary, so a mid-period change never shortens or stretches the period in progress. Words below the minimum ratio of 240 cannot guarantee M ≥ A. Such words are flagged and are not loaded.

Top module: `psw_fbdiv`

## Requirements
- R1: The ratio word splits into A = ratio_i[3:0] and M = ratio_i[14:4]. Between consecutive rising edges of fpd_o there are exactly 16·M + A clk_i cycles.
- R2: Each prescaler cycle lasts 16 or 17 clocks. Within a period the first A cycles last 17 clocks and the remaining cycles last 16, so a word with A = 15 yields 16·M + 15.
- R3: A word with A = 0 gives a period of exactly 16·M clocks, with no 17-clock cycle.
- R4: fpd_o is high for exactly one clk_i cycle per period.
- R5: fpd_half_o toggles in the same cycle that fpd_o goes high, giving a square wave with a period of 2·N clocks.
- R6: ratio_i is sampled only at a period boundary. A change made mid-period leaves the current period at the old ratio, and the next period uses the new one.
- R7: ratio_err_o is high whenever ratio_i < 240, independent of reset. At a boundary an out-of-range word is not loaded, and the previously loaded word is reused.
- R8: During reset fpd_o and fpd_half_o are 0. The first clock edge after reset release loads ratio_i (or 240 if it is out of range), and the first fpd_o pulse follows N clocks later.
- R9: The full range from 240 to 32767 is supported, including both endpoints.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 15 | Division ratio word, {M[10:0], A[3:0]} |
| fpd_o | output | 1 | One-clock pulse per divided period |
| fpd_half_o | output | 1 | Divided output toggled per period (half rate) |
| ratio_err_o | output | 1 | ratio_i below the minimum ratio |

## Verification
The bench measures the interval between pulses in clock cycles for several kinds of ratio word:
- A mid-range word with a non-zero swallow count, which separates correct 16·M + A arithmetic from a swapped or misaligned split.
- A = 15, which exposes any off-by-one in the 17-cycle count.
- A = 0, which catches a stray 17-clock cycle.
- The endpoints 240 and 32767, which probe counter widths.

Changing the word mid-period shows whether loading waits for the boundary. Out-of-range words are checked both on the flag and by the period that follows them. The first pulse after reset is timed to pin down the initial load.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned A_W_DEF       = 4;
  localparam int unsigned M_W_DEF       = 11;
  localparam int unsigned MIN_RATIO_DEF = 240;
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int unsigned A_W = psw_pkg::A_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel17_i,
  output logic tc_o
);
  localparam int unsigned PC_W = A_W + 1;
  localparam logic [PC_W-1:0] TOP16 = PC_W'((2 ** A_W) - 1);
  localparam logic [PC_W-1:0] TOP17 = PC_W'(2 ** A_W);

  logic [PC_W-1:0] pc_q;

  assign tc_o = (pc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= '0;
    else if (tc_o) pc_q <= sel17_i ? TOP17 : TOP16;
    else           pc_q <= pc_q - 1'b1;
  end

  AST_PC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= TOP17) else $error("pc out of range"); // R2
  AST_MOD_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> (pc_q == ($past(sel17_i) ? TOP17 : TOP16))) else $error("bad modulus"); // R2
endmodule

// File: rtl/psw_swallow_ctl.sv
module psw_swallow_ctl #(
  parameter int unsigned A_W       = psw_pkg::A_W_DEF,
  parameter int unsigned M_W       = psw_pkg::M_W_DEF,
  parameter int unsigned MIN_RATIO = psw_pkg::MIN_RATIO_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tc_i,
  input  logic [A_W+M_W-1:0] ratio_i,
  output logic             sel17_o,
  output logic             bound_o,
  output logic             err_o
);
  localparam int unsigned RW = A_W + M_W;

  logic [RW-1:0]  word_q;
  logic [A_W-1:0] a_left_q;
  logic [M_W-1:0] m_left_q;
  logic           init_q;

  logic           valid;
  logic [RW-1:0]  eff;
  logic [A_W-1:0] new_a;
  logic [M_W-1:0] new_m;
  logic           at_end;

  assign valid  = (ratio_i >= RW'(MIN_RATIO));
  assign err_o  = !valid;
  assign eff    = valid ? ratio_i : word_q;
  assign new_a  = eff[A_W-1:0];
  assign new_m  = eff[RW-1:A_W];
  assign at_end = tc_i && (m_left_q == M_W'(1));

  // a_left_q: 17-cycles still to start after the current prescaler cycle
  assign sel17_o = at_end ? (new_a != '0) : (a_left_q != '0);
  assign bound_o = at_end && !init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= RW'(MIN_RATIO);
      a_left_q <= '0;
      m_left_q <= M_W'(1);
      init_q   <= 1'b1;
    end else if (tc_i) begin
      if (at_end) begin
        m_left_q <= new_m;
        a_left_q <= (new_a != '0) ? A_W'(new_a - 1'b1) : '0;
        init_q   <= 1'b0;
        if (valid) word_q <= ratio_i;
      end else begin
        m_left_q <= m_left_q - 1'b1;
        if (a_left_q != '0) a_left_q <= a_left_q - 1'b1;
      end
    end
  end

  AST_M_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_left_q != '0) else $error("cycle count hit zero"); // R1
  AST_A_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    M_W'(a_left_q) < m_left_q) else $error("swallow exceeds cycles"); // R2
  AST_BAD_WORD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && err_o) |=> $stable(word_q)) else $error("bad word loaded"); // R7
  AST_MID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_end |=> $stable(word_q)) else $error("word changed mid-period"); // R6
endmodule

// File: rtl/psw_out.sv
module psw_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bound_i,
  output logic fpd_o,
  output logic half_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fpd_o  <= 1'b0;
      half_o <= 1'b0;
    end else begin
      fpd_o <= bound_i;
      if (bound_i) half_o <= !half_o;
    end
  end

  AST_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpd_o |=> !fpd_o) else $error("pulse wider than one clock"); // R4
  AST_HALF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpd_o |-> (half_o != $past(half_o))) else $error("half missed toggle"); // R5
  AST_HALF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fpd_o |-> $stable(half_o)) else $error("half stray toggle"); // R5
endmodule

// File: rtl/psw_fbdiv.sv
module psw_fbdiv #(
  parameter int unsigned A_W       = psw_pkg::A_W_DEF,
  parameter int unsigned M_W       = psw_pkg::M_W_DEF,
  parameter int unsigned MIN_RATIO = psw_pkg::MIN_RATIO_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [A_W+M_W-1:0] ratio_i,
  output logic               fpd_o,
  output logic               fpd_half_o,
  output logic               ratio_err_o
);
  logic sel17, tc, bound;

  psw_prescaler #(.A_W(A_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel17_i (sel17),
    .tc_o    (tc)
  );

  psw_swallow_ctl #(.A_W(A_W), .M_W(M_W), .MIN_RATIO(MIN_RATIO)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tc_i    (tc),
    .ratio_i (ratio_i),
    .sel17_o (sel17),
    .bound_o (bound),
    .err_o   (ratio_err_o)
  );

  psw_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bound_i (bound),
    .fpd_o   (fpd_o),
    .half_o  (fpd_half_o)
  );
endmodule

// File: tb/psw_fbdiv_bench.sv
`timescale 1ns/1ps
module psw_fbdiv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] ratio = 15'd1000;
  logic        fpd, fpd_half, rerr;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psw_fbdiv u_psw_fbdiv (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio),
    .fpd_o(fpd), .fpd_half_o(fpd_half), .ratio_err_o(rerr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_pulse(output int t);
    do @(negedge clk); while (!fpd);
    t = cyc;
  endtask

  task automatic run_ratio(input string req, input int r);
    int t0, t1;
    logic h0;
    ratio = 15'(r);
    next_pulse(t0);
    h0 = fpd_half;
    next_pulse(t1);
    chk(req, t1 - t0, r);
    chk("R5 half toggles per pulse", int'(fpd_half != h0), 1);
  endtask

  task automatic t_reset;
    int c0, t;
    repeat (3) @(negedge clk);
    chk("R8 fpd low in reset", int'(fpd), 0);
    chk("R8 half low in reset", int'(fpd_half), 0);
    chk("R7 flag low for 1000", int'(rerr), 0);
    ratio = 15'd100;
    #1 chk("R7 flag high for 100 in reset", int'(rerr), 1);
    ratio = 15'd1000;
    @(negedge clk);
    c0 = cyc;
    rst_n = 1'b1;
    next_pulse(t);
    chk("R8 first pulse delay", t - c0, 1000 + 1);
  endtask

  task automatic t_width;
    int t;
    next_pulse(t);
    @(negedge clk);
    chk("R4 pulse one clock wide", int'(fpd), 0);
  endtask

  task automatic t_mid_change;
    int t0, t1, t2;
    ratio = 15'd1000;
    next_pulse(t0);
    next_pulse(t0);
    repeat (300) @(negedge clk);
    ratio = 15'd500;
    next_pulse(t1);
    chk("R6 current period keeps old word", t1 - t0, 1000);
    next_pulse(t2);
    chk("R6 next period uses new word", t2 - t1, 500);
  endtask

  task automatic t_bad_word;
    int t0, t1;
    ratio = 15'd239;
    #1 chk("R7 flag for 239", int'(rerr), 1);
    ratio = 15'd240;
    #1 chk("R7 no flag for 240", int'(rerr), 0);
    ratio = 15'd100;
    #1 chk("R7 flag for 100", int'(rerr), 1);
    next_pulse(t0);
    next_pulse(t1);
    chk("R7 out-of-range word ignored", t1 - t0, 500);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_width();
    run_ratio("R1 ratio 1000 (M=62,A=8)", 1000);
    run_ratio("R2 ratio 255 (M=15,A=15)", 255);
    run_ratio("R3 ratio 256 (M=16,A=0)", 256);
    run_ratio("R1 ratio 4111 (M=256,A=15)", 4111);
    run_ratio("R9 minimum ratio 240", 240);
    t_mid_change();
    t_bad_word();
    run_ratio("R9 maximum ratio 32767", 32767);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule